// File: doc/BRIEF.md
# Buffer-Occupancy Memory Port Arbiter

This block decides who uses a single shared main-memory port (24-bit words) each memory cycle. There are five requesters: a central processor and four I/O channels. The channels are called W, Y, C and D, with index 0 to 3 in that order. Each channel raises a request and reports a 4-bit count of how full its local buffer is. The processor raises its own request. It also raises a slot signal at the points in its instruction cycle where a channel may take the memory.

Arbitration happens only on a clock edge at which the memory is idle. A channel is eligible only when the slot signal is high at that edge. Any eligible channel beats the processor. Among eligible channels, the one with the highest occupancy wins, so channel priority changes from cycle to cycle as buffers fill and drain. The winner gets a one-hot grant. The grant is held, together with a busy flag, for a fixed memory cycle and cannot be preempted. Nothing else is sampled until the grant is released.

Each request behaves like a valid signal and its grant like the matching ready. A requester keeps its request high until it sees its grant. A request that loses, or that waits for a slot, is simply sampled again at the next idle edge. The block stores no pending state, so the requester provides the back-pressure by holding its request.

Top module: `mem_port_arbiter`

## Requirements
- R1: While reset is asserted, and on the first clock after it, every grant output is low and `mem_busy` is low.
- R2: At an idle edge where `cpu_slot` is high and at least one channel requests, a channel is granted and the processor is not, even if it requests.
- R3: Among channels requesting at an idle edge with `cpu_slot` high, the grant goes to the one whose unsigned 4-bit occupancy on `ch_occ[4*i+3:4*i]` is strictly greatest.
- R4: When several such channels share the greatest occupancy, the lowest index wins (W=0, then Y=1, C=2, D=3).
- R5: At an idle edge with `cpu_slot` low, no channel is granted. A channel whose request is still held is granted at a later idle edge where the slot is open.
- R6: When no channel is eligible at an idle edge, a requesting processor is granted, even if a channel is waiting for a slot.
- R7: A grant, with `mem_busy` high, appears one clock after the idle edge that decided it and lasts exactly MEM_CYC clocks (default 4). Changes on any request, occupancy or slot input during that time have no effect on it.
- R8: At most one of the five grant outputs is high in any clock.
- R9: After a grant ends, the port is idle for at least one clock before the next grant. `mem_busy` is low exactly when no grant is high.
- R10: An idle edge with no request at all leaves the port idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_req | input | 4 | Channel requests, bit i = channel i (W,Y,C,D) |
| ch_occ | input | 16 | Buffer occupancy, 4 bits per channel, channel i at [4i+3:4i] |
| cpu_req | input | 1 | Processor memory request |
| cpu_slot | input | 1 | Processor allows a channel to take the memory at this edge |
| ch_gnt | output | 4 | One-hot channel grant |
| cpu_gnt | output | 1 | Processor grant |
| mem_busy | output | 1 | A memory cycle is in progress |

## Verification
The assertions assume the inputs are clean, known values at every rising edge. They also assume that the occupancy bus means something only for channels that request, and that reset is held for at least one edge. They make no assumption about requests being held, because the block keeps no memory of losers.

The stimulus changes inputs only on falling edges and waits for each memory cycle to end before presenting the next pattern. During every hold it drives a deliberately stronger pattern, with all channels requesting at full occupancy, the slot open and the processor requesting, so that any preemption would show up. Expected grants come from an independent reference function applied to the pattern that was present at the deciding edge.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } port_state_e;

  localparam int unsigned WORD_W = 24;
endpackage

// File: rtl/mpa_pick.sv
module mpa_pick #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned OCC_W = 4
) (
  input  logic [NCH-1:0]       elig,
  input  logic [NCH*OCC_W-1:0] occ,
  output logic [NCH-1:0]       win,
  output logic                 any_win
);
  localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [OCC_W-1:0] occ_a [NCH];
  logic [OCC_W-1:0] best;
  logic [IDX_W-1:0] sel;
  logic             found;

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign occ_a[g] = occ[g*OCC_W +: OCC_W];
  end

  // strict '>' keeps the earlier (lower index) channel on a tie
  always_comb begin
    best  = '0;
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (elig[i] && (!found || occ_a[i] > best)) begin
        found = 1'b1;
        best  = occ_a[i];
        sel   = IDX_W'(i);
      end
    end
  end

  assign any_win = found;
  assign win     = found ? (NCH'(1) << sel) : '0;

  always_comb begin
    if (any_win) assert ($onehot(win) && ((win & ~elig) == '0))
      else $error("p_pick_eligible_r3 violated");
  end
endmodule

// File: rtl/mpa_hold.sv
module mpa_hold
  import mpa_pkg::*;
#(
  parameter int unsigned GW      = 5,
  parameter int unsigned MEM_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [GW-1:0] load_gnt,
  output logic [GW-1:0] gnt,
  output logic          busy
);
  localparam int unsigned CNT_W = (MEM_CYC > 1) ? $clog2(MEM_CYC) : 1;

  port_state_e      st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      gnt   <= '0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (load) begin
            gnt   <= load_gnt;
            cnt_q <= CNT_W'(MEM_CYC - 1);
            st_q  <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) begin
            gnt  <= '0;
            st_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q == ST_HOLD);

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != '0) |=> (busy && $stable(gnt)));

  p_release_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q == '0) |=> (!busy && gnt == '0));
endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter #(
  parameter int unsigned NCH     = 4,
  parameter int unsigned OCC_W   = 4,
  parameter int unsigned MEM_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       ch_req,
  input  logic [NCH*OCC_W-1:0] ch_occ,
  input  logic                 cpu_req,
  input  logic                 cpu_slot,
  output logic [NCH-1:0]       ch_gnt,
  output logic                 cpu_gnt,
  output logic                 mem_busy
);
  localparam int unsigned GW = NCH + 1;

  logic [NCH-1:0] elig;
  logic [NCH-1:0] ch_win;
  logic           ch_any;
  logic           cpu_win;
  logic           load;
  logic [GW-1:0]  gnt_all;

  assign elig    = ch_req & {NCH{cpu_slot}};
  assign cpu_win = cpu_req && !ch_any;
  assign load    = !mem_busy && (ch_any || cpu_req);

  mpa_pick #(.NCH(NCH), .OCC_W(OCC_W)) pick_i (
    .elig    (elig),
    .occ     (ch_occ),
    .win     (ch_win),
    .any_win (ch_any)
  );

  mpa_hold #(.GW(GW), .MEM_CYC(MEM_CYC)) hold_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_gnt ({cpu_win, ch_win}),
    .gnt      (gnt_all),
    .busy     (mem_busy)
  );

  assign ch_gnt  = gnt_all[NCH-1:0];
  assign cpu_gnt = gnt_all[NCH];

  // ---------------- assertions ----------------
  p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_gnt, ch_gnt}));

  p_busy_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_busy == ({cpu_gnt, ch_gnt} != '0));

  p_chan_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_busy && cpu_slot && ch_req != '0) |=> (!cpu_gnt && ch_gnt != '0));

  p_no_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_busy && !cpu_slot) |=> (ch_gnt == '0));

  p_cpu_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_busy && cpu_req && !(cpu_slot && ch_req != '0)) |=> cpu_gnt);

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_busy && !cpu_req && ch_req == '0) |=> !mem_busy);

  // pairwise: a channel beaten on occupancy, or tied by a lower index, never wins
  for (genvar i = 0; i < NCH; i++) begin : g_pa
    for (genvar j = 0; j < NCH; j++) begin : g_pb
      if (i != j) begin : g_pair
        p_fullest_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
          (!mem_busy && cpu_slot && ch_req[i] && ch_req[j] &&
           ((ch_occ[i*OCC_W +: OCC_W] > ch_occ[j*OCC_W +: OCC_W]) ||
            ((ch_occ[i*OCC_W +: OCC_W] == ch_occ[j*OCC_W +: OCC_W]) && (i < j))))
          |=> !ch_gnt[j]);
      end
    end
  end
endmodule

// File: tb/mem_port_arbiter_tb_top.sv
`timescale 1ns/1ps
module mem_port_arbiter_tb_top;
  localparam int unsigned NCH     = 4;
  localparam int unsigned OCC_W   = 4;
  localparam int unsigned MEM_CYC = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NCH-1:0]       ch_req = '0;
  logic [NCH*OCC_W-1:0] ch_occ = '0;
  logic                 cpu_req = 1'b0;
  logic                 cpu_slot = 1'b0;
  logic [NCH-1:0]       ch_gnt;
  logic                 cpu_gnt;
  logic                 mem_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [NCH:0] exp_q [$];
  string        tag_q [$];
  event kick, done;

  always #2 clk = ~clk;

  mem_port_arbiter #(.NCH(NCH), .OCC_W(OCC_W), .MEM_CYC(MEM_CYC)) dut_i (
    .clk, .rst_n, .ch_req, .ch_occ, .cpu_req, .cpu_slot,
    .ch_gnt, .cpu_gnt, .mem_busy
  );

  // reference derived from the requirements
  function automatic logic [NCH:0] ref_gnt(logic [NCH-1:0] rq, logic [NCH*OCC_W-1:0] oc,
                                           logic cr, logic sl);
    int bi = -1;
    logic [OCC_W-1:0] bv = '0;
    for (int i = 0; i < NCH; i++)
      if (sl && rq[i] && (bi < 0 || oc[i*OCC_W +: OCC_W] > bv)) begin
        bi = i; bv = oc[i*OCC_W +: OCC_W];
      end
    if (bi >= 0) return (NCH+1)'(1) << bi;
    if (cr) return (NCH+1)'(1) << NCH;
    return '0;
  endfunction

  task automatic check(bit ok, string tag, logic [NCH+1:0] act, logic [NCH+1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (busy,cpu,ch)", tag, act, exp);
    end
  endtask

  task automatic apply(logic [NCH-1:0] rq, logic [NCH*OCC_W-1:0] oc,
                       logic cr, logic sl, string tag);
    logic [NCH:0] e;
    @(negedge clk);
    ch_req = rq; ch_occ = oc; cpu_req = cr; cpu_slot = sl;
    e = ref_gnt(rq, oc, cr, sl);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    -> kick;
    if (e != '0) begin
      @(negedge clk);
      ch_req = '1; ch_occ = '1; cpu_req = 1'b1; cpu_slot = 1'b1;  // R7 disturbance
    end
    @(done);
    ch_req = '0; ch_occ = '0; cpu_req = 1'b0; cpu_slot = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      logic [NCH:0] e;
      string t;
      @(kick);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      @(negedge clk);
      check({cpu_gnt, ch_gnt} == e && mem_busy == (e != '0), t,
            {mem_busy, cpu_gnt, ch_gnt}, {(e != '0), e});
      if (e != '0) begin
        for (int k = 1; k < MEM_CYC; k++) begin
          @(negedge clk);
          check({cpu_gnt, ch_gnt} == e && mem_busy, "R7 hold",
                {mem_busy, cpu_gnt, ch_gnt}, {1'b1, e});
        end
        @(negedge clk);
        check({cpu_gnt, ch_gnt} == '0 && !mem_busy, "R9 release",
              {mem_busy, cpu_gnt, ch_gnt}, '0);
      end
      -> done;
    end
  end

  // occupancy helper: channel order W,Y,C,D in ascending nibble positions
  function automatic logic [15:0] occ4(logic [3:0] w, logic [3:0] y, logic [3:0] c, logic [3:0] d);
    return {d, c, y, w};
  endfunction

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    check({cpu_gnt, ch_gnt} == '0 && !mem_busy, "R1 in reset", {mem_busy, cpu_gnt, ch_gnt}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check({cpu_gnt, ch_gnt} == '0 && !mem_busy, "R1 after reset", {mem_busy, cpu_gnt, ch_gnt}, '0);

    apply(4'b0000, '0, 1'b1, 1'b0, "R6 cpu alone");
    apply(4'b0000, '0, 1'b0, 1'b1, "R10 nothing requested");
    apply(4'b0100, occ4(0, 0, 5, 0), 1'b0, 1'b0, "R5 no slot, channel waits");
    apply(4'b0100, occ4(0, 0, 5, 0), 1'b0, 1'b1, "R5 slot opens, channel granted");
    apply(4'b1000, occ4(0, 0, 0, 1), 1'b1, 1'b1, "R2 channel beats cpu");
    apply(4'b0011, occ4(9, 9, 0, 0), 1'b1, 1'b0, "R6 cpu while channels wait");
    apply(4'b0011, occ4(3, 7, 0, 0), 1'b0, 1'b1, "R3 Y fuller than W");
    apply(4'b1111, occ4(2, 4, 6, 15), 1'b1, 1'b1, "R3 D fullest");
    apply(4'b1111, occ4(14, 15, 13, 0), 1'b0, 1'b1, "R3 15 beats 14");
    apply(4'b0101, occ4(8, 0, 8, 0), 1'b0, 1'b1, "R4 tie W over C");
    apply(4'b1010, occ4(0, 6, 0, 6), 1'b1, 1'b1, "R4 tie Y over D");
    apply(4'b1111, occ4(0, 0, 0, 0), 1'b0, 1'b1, "R4 all empty tie W");
    apply(4'b0111, occ4(1, 9, 9, 15), 1'b0, 1'b1, "R3 D not requesting, Y over C");

    s = 32'h1234_5678;
    for (int v = 0; v < 40; v++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      apply(s[3:0], s[19:4], s[20], s[21] | s[22], "R3 mixed pattern");
    end

    // R8 spot-check across idle/busy boundaries is done by every compare above
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule